// File: doc/BRIEF.md
# Quad-Phase Instruction Sequencer

This block is the timing heart of a small single-issue controller core. It counts the input oscillator through four repeating, non-overlapping phases, Q1 to Q4. One pass through all four phases is one instruction cycle. The phases set the times at which the program counter moves, the program word is captured, and data memory is read and written. It also brings out a square wave at one quarter of the oscillator rate.

Fetch and execute overlap. While the instruction register holds the word being executed, the program counter already addresses the next word. That word is captured at the end of the cycle. When the executing instruction redirects control, it raises a branch request with a target. At the cycle boundary the counter loads the target, and the prefetched word is replaced by a no-op. That no-op cycle runs with its data write suppressed, so every control transfer costs two cycles.

The program word arrives on a plain bus, and the block samples it at one fixed phase. There is no valid/ready handshake and no back-pressure. The program memory must present the word for the current counter value by the end of Q4. The core cannot be stalled.

Top module: `qps_seq`

## Requirements
- R1: A synchronous reset puts the phase at Q1, the program counter at 0, the instruction register at the no-op word and the flush flag at 0. The first fetched instruction executes in the second instruction cycle after reset.
- R2: `q_strb` is always exactly one-hot, with bit 0 = Q1, bit 1 = Q2, bit 2 = Q3 and bit 3 = Q4. It advances one bit per clock, in the order Q1, Q2, Q3, Q4, Q1.
- R3: `clk_out` is low during Q1 and Q2 and high during Q3 and Q4.
- R4: With no branch taken, the program counter rises by one on the edge that enters Q1. It does not change on any other edge.
- R5: The program counter wraps from its all-ones value to 0.
- R6: `pm_latch` is high only in Q4. The instruction register takes the `pm_word` present at the edge leaving Q4, shows it from Q1 onward, and holds it for the whole cycle.
- R7: `dm_rd` is high only in Q2, in every cycle, including flushed ones.
- R8: `dm_wr` is high in Q4 unless the cycle is a flushed no-op cycle, in which case it stays low.
- R9: When `br_taken` is high during Q4, the next cycle starts with `pc_o` equal to the `br_target` sampled then, `ir_o` equal to the no-op word and `flush_o` high. The cycle after that executes the word fetched from the target.
- R10: `br_taken` during Q1, Q2 or Q3 has no effect on the program counter, the instruction register or the flush flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| br_taken | input | 1 | Branch request from the executing instruction, sampled in Q4 |
| br_target | input | PC_W | Branch destination address |
| pm_word | input | IW | Program word at address `pc_o` |
| pc_o | output | PC_W | Program counter / program memory address |
| ir_o | output | IW | Instruction register (word being executed) |
| q_strb | output | 4 | One-hot phase strobes, bit 0 = Q1 |
| pm_latch | output | 1 | Program word capture strobe (Q4) |
| dm_rd | output | 1 | Data operand read strobe (Q2) |
| dm_wr | output | 1 | Data destination write strobe (Q4, not in flushed cycles) |
| flush_o | output | 1 | High for the whole forced no-op cycle |
| clk_out | output | 1 | Oscillator divided by four, 50% duty |

## Verification
The properties treat `br_taken` as meaningful only at the Q4 edge. They also assume that `pm_word` has settled by that same edge, because the instruction-register check compares against the word sampled there. The bench models program memory as a pure function of `pc_o`, so the word is always stable before Q4 ends. It raises branch requests only in Q4 for real transfers. Stray pulses in Q2 are added separately, and the bench confirms they change nothing. Branch targets sit near the top of a 4-bit address space, so both wrap-around and redirects are exercised many times.

// File: rtl/qps_pkg.sv
package qps_pkg;
  localparam int NUM_PH = 4;
  localparam int PH_W   = 2;

  typedef enum logic [PH_W-1:0] {
    PH_Q1 = 2'd0,
    PH_Q2 = 2'd1,
    PH_Q3 = 2'd2,
    PH_Q4 = 2'd3
  } qph_e;
endpackage

// File: rtl/qps_phase_gen.sv
module qps_phase_gen
  import qps_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output qph_e              ph_o,
  output logic [NUM_PH-1:0] q_strb,
  output logic              cyc_end,
  output logic              clk_out
);
  logic [PH_W-1:0] ph_cnt;
  logic [PH_W-1:0] ph_nxt;
  logic            clk_q;

  // wraps naturally since NUM_PH is a power of two
  assign ph_nxt = ph_cnt + PH_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_cnt <= PH_W'(PH_Q1);
      clk_q  <= 1'b0;
    end else begin
      ph_cnt <= ph_nxt;
      // high for the upper half of the cycle (Q3, Q4)
      clk_q  <= ph_nxt[PH_W-1];
    end
  end

  for (genvar i = 0; i < NUM_PH; i++) begin : g_strb
    assign q_strb[i] = (ph_cnt == PH_W'(i));
  end

  assign ph_o    = qph_e'(ph_cnt);
  assign cyc_end = (ph_cnt == PH_W'(PH_Q4));
  assign clk_out = clk_q;
endmodule

// File: rtl/qps_pc.sv
module qps_pc #(
  parameter int PC_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  input  logic            ld,
  input  logic [PC_W-1:0] tgt,
  output logic [PC_W-1:0] pc_o
);
  localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q <= '0;
    end else if (adv) begin
      pc_q <= ld ? tgt : (pc_q + PC_STEP);
    end
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/qps_ir.sv
module qps_ir #(
  parameter int            IW       = 14,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  input  logic          br,
  input  logic [IW-1:0] pm_word,
  output logic [IW-1:0] ir_o,
  output logic          flush_o
);
  logic [IW-1:0] ir_q;
  logic          flush_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q    <= NOP_WORD;
      flush_q <= 1'b0;
    end else if (adv) begin
      ir_q    <= br ? NOP_WORD : pm_word;
      flush_q <= br;
    end
  end

  assign ir_o    = ir_q;
  assign flush_o = flush_q;
endmodule

// File: rtl/qps_memstb.sv
module qps_memstb
  import qps_pkg::*;
(
  input  qph_e ph,
  input  logic flush,
  output logic pm_latch,
  output logic dm_rd,
  output logic dm_wr
);
  always_comb begin
    pm_latch = 1'b0;
    dm_rd    = 1'b0;
    dm_wr    = 1'b0;
    unique case (ph)
      PH_Q2:   dm_rd = 1'b1;
      PH_Q4: begin
        pm_latch = 1'b1;
        dm_wr    = ~flush;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/qps_seq.sv
module qps_seq
  import qps_pkg::*;
#(
  parameter int            PC_W     = 8,
  parameter int            IW       = 14,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              br_taken,
  input  logic [PC_W-1:0]   br_target,
  input  logic [IW-1:0]     pm_word,
  output logic [PC_W-1:0]   pc_o,
  output logic [IW-1:0]     ir_o,
  output logic [NUM_PH-1:0] q_strb,
  output logic              pm_latch,
  output logic              dm_rd,
  output logic              dm_wr,
  output logic              flush_o,
  output logic              clk_out
);
  qph_e ph;
  logic cyc_end;
  logic flush_w;

  qps_phase_gen u_phase (
    .clk     (clk),
    .rst     (rst),
    .ph_o    (ph),
    .q_strb  (q_strb),
    .cyc_end (cyc_end),
    .clk_out (clk_out)
  );

  qps_pc #(.PC_W(PC_W)) u_pc (
    .clk  (clk),
    .rst  (rst),
    .adv  (cyc_end),
    .ld   (br_taken),
    .tgt  (br_target),
    .pc_o (pc_o)
  );

  qps_ir #(.IW(IW), .NOP_WORD(NOP_WORD)) u_ir (
    .clk     (clk),
    .rst     (rst),
    .adv     (cyc_end),
    .br      (br_taken),
    .pm_word (pm_word),
    .ir_o    (ir_o),
    .flush_o (flush_w)
  );

  qps_memstb u_mem (
    .ph       (ph),
    .flush    (flush_w),
    .pm_latch (pm_latch),
    .dm_rd    (dm_rd),
    .dm_wr    (dm_wr)
  );

  assign flush_o = flush_w;
endmodule

// File: rtl/qps_seq_chk.sv
module qps_seq_chk #(
  parameter int            PC_W     = 8,
  parameter int            IW       = 14,
  parameter logic [IW-1:0] NOP_WORD = '0
) (
  input logic            clk,
  input logic            rst,
  input logic            br_taken,
  input logic [PC_W-1:0] br_target,
  input logic [IW-1:0]   pm_word,
  input logic [PC_W-1:0] pc_o,
  input logic [IW-1:0]   ir_o,
  input logic [3:0]      q_strb,
  input logic            pm_latch,
  input logic            dm_rd,
  input logic            dm_wr,
  input logic            flush_o,
  input logic            clk_out
);
  p_onehot_r2: assert property (@(posedge clk) disable iff (rst)
    $countones(q_strb) == 1);
  p_q1q2_r2: assert property (@(posedge clk) disable iff (rst)
    q_strb[0] |=> q_strb[1]);
  p_q2q3_r2: assert property (@(posedge clk) disable iff (rst)
    q_strb[1] |=> q_strb[2]);
  p_q3q4_r2: assert property (@(posedge clk) disable iff (rst)
    q_strb[2] |=> q_strb[3]);
  p_q4q1_r2: assert property (@(posedge clk) disable iff (rst)
    q_strb[3] |=> q_strb[0]);
  p_clk_low_r3: assert property (@(posedge clk) disable iff (rst)
    (q_strb[0] || q_strb[1]) |-> !clk_out);
  p_clk_high_r3: assert property (@(posedge clk) disable iff (rst)
    (q_strb[2] || q_strb[3]) |-> clk_out);
  p_pc_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (q_strb[3] && !br_taken) |=> pc_o == PC_W'($past(pc_o) + PC_W'(1)));
  p_pc_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !q_strb[3] |=> $stable(pc_o));
  p_ir_load_r6: assert property (@(posedge clk) disable iff (rst)
    (q_strb[3] && !br_taken) |=> (ir_o == $past(pm_word)) && !flush_o);
  p_ir_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !q_strb[3] |=> $stable(ir_o) && $stable(flush_o));
  p_latch_r6: assert property (@(posedge clk) disable iff (rst)
    pm_latch |-> q_strb[3]);
  p_rd_r7: assert property (@(posedge clk) disable iff (rst)
    dm_rd == q_strb[1]);
  p_wr_r8: assert property (@(posedge clk) disable iff (rst)
    dm_wr == (q_strb[3] && !flush_o));
  p_branch_r9: assert property (@(posedge clk) disable iff (rst)
    (q_strb[3] && br_taken) |=>
      (pc_o == $past(br_target)) && (ir_o == NOP_WORD) && flush_o);
endmodule

bind qps_seq qps_seq_chk #(.PC_W(PC_W), .IW(IW), .NOP_WORD(NOP_WORD)) chk_i (.*);

// File: tb/qps_seq_tb.sv
`timescale 1ns/1ps
module qps_seq_tb_top;
  localparam int            PC_W  = 4;
  localparam int            IW    = 8;
  localparam logic [IW-1:0] NOP_W = 8'h00;
  localparam int            NCYC  = 200;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            br_taken = 1'b0;
  logic [PC_W-1:0] br_target = '0;
  logic [IW-1:0]   pm_word;
  logic [PC_W-1:0] pc_o;
  logic [IW-1:0]   ir_o;
  logic [3:0]      q_strb;
  logic            pm_latch, dm_rd, dm_wr, flush_o, clk_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  function automatic logic [IW-1:0] mem_f(input logic [PC_W-1:0] a);
    return {a ^ 4'h5, a};
  endfunction

  assign pm_word = mem_f(pc_o);

  qps_seq #(.PC_W(PC_W), .IW(IW), .NOP_WORD(NOP_W)) dut_i (
    .clk(clk), .rst(rst), .br_taken(br_taken), .br_target(br_target),
    .pm_word(pm_word), .pc_o(pc_o), .ir_o(ir_o), .q_strb(q_strb),
    .pm_latch(pm_latch), .dm_rd(dm_rd), .dm_wr(dm_wr),
    .flush_o(flush_o), .clk_out(clk_out)
  );

  task automatic chk(input bit ok, input string req,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    logic [PC_W-1:0] e_pc;
    logic [IW-1:0]   e_ir;
    logic            e_fl;
    string           pc_tag, ir_tag;
    e_pc = '0; e_ir = NOP_W; e_fl = 1'b0;
    pc_tag = "R1"; ir_tag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // still in Q1 established by the last reset edge
    chk(q_strb == 4'b0001, "R1", q_strb, 4'b0001);
    chk(flush_o == 1'b0, "R1", flush_o, 0);
    for (int c = 0; c < NCYC; c++) begin
      bit do_br, do_ign;
      logic [PC_W-1:0] tgt;
      do_br  = (c % 7 == 3);
      do_ign = (c % 5 == 1);
      tgt    = PC_W'(12 + (c % 4));
      for (int p = 0; p < 4; p++) begin
        chk(q_strb == 4'(1 << p), "R2", q_strb, 1 << p);
        chk(clk_out == (p >= 2), "R3", clk_out, p >= 2);
        chk(dm_rd == (p == 1), "R7", dm_rd, p == 1);
        chk(dm_wr == (p == 3 && !e_fl), "R8", dm_wr, p == 3 && !e_fl);
        chk(pm_latch == (p == 3), "R6", pm_latch, p == 3);
        chk(pc_o == e_pc, pc_tag, pc_o, e_pc);
        chk(ir_o == e_ir, ir_tag, ir_o, e_ir);
        chk(flush_o == e_fl, (e_fl ? "R9" : ir_tag), flush_o, e_fl);
        // drive the request seen by the next edge
        br_taken  = (p == 3) ? do_br : (p == 1 && do_ign);
        br_target = (p == 3) ? tgt : ~tgt;
        @(negedge clk);
        br_taken = 1'b0;
      end
      if (do_br) begin
        e_pc = tgt; e_ir = NOP_W; e_fl = 1'b1;
        pc_tag = "R9"; ir_tag = "R9";
      end else begin
        e_ir = mem_f(e_pc);
        pc_tag = (e_pc == '1) ? "R5" : (do_ign ? "R10" : "R4");
        ir_tag = do_ign ? "R10" : ((c == 0) ? "R1" : "R6");
        e_pc = e_pc + 1'b1;
        e_fl = 1'b0;
      end
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule